// File: doc/BRIEF.md
# Serial Recirculating Word Store

This block models a word memory made of several circulating lines ("organs"). Every organ holds 32 words of 32 bits. The bits move one place per clock and leave the line at a single tap. From the tap they return to the entry of the same line. One full lap of an organ takes 1024 clocks. All organs share one global lap counter, so the word slot at the tap is known in every cycle.

A request gives a 13-bit word address and a direction flag. The upper 8 address bits choose the organ and the lower 5 bits choose the word slot. The controller takes the request only when it is idle. It then waits until the requested slot reaches the tap. After that it either streams the 32 stored bits out serially or replaces them with 32 serial input bits. The wait therefore depends on where the word sits in its lap when the request arrives. A one-cycle completion pulse follows the last bit. An address that names an organ beyond the configured count is refused with an error pulse.

Top module: `dlm_mem`

## Requirements
- R1: With no access, stored words keep their value for any length of time; a word read thousands of cycles after it was written returns the written value.
- R2: Address bits [12:5] select the organ and bits [4:0] select the word slot within that organ; words with equal slot numbers in different organs are independent.
- R3: The first data cycle of an access is the first cycle after acceptance in which the shared counter is at bit 0 of the requested slot. A request accepted in the cycle where the counter is at that point waits a full 1024-cycle lap. A request accepted one cycle earlier starts in the very next cycle.
- R4: A read asserts rd_valid for 32 consecutive cycles and presents the word on rd_bit least significant bit first. The stored word is unchanged, so a second read returns the same value.
- R5: A write asserts wr_take for 32 consecutive cycles and stores the value of wr_bit sampled in each of those cycles, least significant bit first. Every other word is unchanged.
- R6: done is high for exactly one cycle, which is the cycle after the last data bit. busy is low in that cycle.
- R7: A request is accepted only while busy is low. A request presented while busy is high has no effect on any stored word and starts no access.
- R8: A request whose organ field is at least NUM_ORGANS raises addr_err for one cycle in the next cycle. It starts no access, leaves busy low and changes no stored word.
- R9: After reset, busy, rd_valid, wr_take, done and addr_err are low and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one bit moves per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address: organ in [12:5], slot in [4:0] |
| wr_bit | input | 1 | Serial write data, sampled in wr_take cycles |
| busy | output | 1 | An accepted request is waiting or transferring |
| wr_take | output | 1 | wr_bit is consumed this cycle |
| rd_valid | output | 1 | rd_bit carries a read data bit this cycle |
| rd_bit | output | 1 | Serial read data, LSB first |
| done | output | 1 | One-cycle pulse after the last data bit |
| addr_err | output | 1 | One-cycle pulse for an out-of-range organ |

## Verification
The hardest cases to reach depend on the lap phase: a request that lands exactly on the target slot's start, and one that lands one cycle before it. The hidden counter is not visible at the ports. The bench therefore measures the phase from the first data cycle of the first read. From then on it predicts the counter value for every cycle, so it can time requests to either edge case and check each start cycle of the following accesses. Requests presented while an access is pending, and requests to organs that do not exist, are followed by read-back of the words they could have changed.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } dlm_state_t;
endpackage

// File: rtl/dlm_timebase.sv
module dlm_timebase #(
  parameter int SLOT_W = 5,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic [BIT_W-1:0]  bitpos
);
  localparam int CNT_W = SLOT_W + BIT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign slot   = cnt_q[CNT_W-1:BIT_W];
  assign bitpos = cnt_q[BIT_W-1:0];
endmodule

// File: rtl/dlm_organ.sv
module dlm_organ #(
  parameter int DEPTH = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic tap
);
  logic [DEPTH-1:0] line_q, line_d;

  // The tap bit re-enters at the far end unless a write substitutes it.
  always_comb begin
    line_d = {(wr_en ? wr_bit : line_q[0]), line_q[DEPTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign tap = line_q[0];
endmodule

// File: rtl/dlm_ctrl.sv
module dlm_ctrl
  import dlm_pkg::*;
#(
  parameter int NUM_ORGANS = 2,
  parameter int ORGAN_W    = 8,
  parameter int SLOT_W     = 5,
  parameter int BIT_W      = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ORGAN_W+SLOT_W-1:0] req_addr,
  input  logic [SLOT_W-1:0]         slot,
  input  logic [BIT_W-1:0]          bitpos,
  output logic                      busy,
  output logic                      xfer,
  output logic                      xfer_write,
  output logic [ORGAN_W-1:0]        sel_organ,
  output logic                      done,
  output logic                      addr_err
);
  localparam int ADDR_W = ORGAN_W + SLOT_W;
  localparam logic [ORGAN_W:0] ORGAN_LIMIT = (ORGAN_W+1)'(NUM_ORGANS);
  localparam logic [BIT_W-1:0] LAST_BIT = {BIT_W{1'b1}};

  dlm_state_t          state_q, state_d;
  logic [ORGAN_W-1:0]  organ_q;
  logic [SLOT_W-1:0]   slot_q;
  logic                write_q;
  logic                done_q, err_q, err_d;
  logic                accept, start_hit, last_bit;
  logic [ORGAN_W-1:0]  req_organ;
  logic [SLOT_W-1:0]   req_slot;

  assign req_organ = req_addr[ADDR_W-1:SLOT_W];
  assign req_slot  = req_addr[SLOT_W-1:0];

  assign start_hit = (state_q == ST_WAIT) && (slot == slot_q) && (bitpos == '0);
  assign xfer      = start_hit || (state_q == ST_XFER);
  assign last_bit  = xfer && (bitpos == LAST_BIT);

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if ({1'b0, req_organ} >= ORGAN_LIMIT) begin
            err_d = 1'b1;
          end else begin
            accept  = 1'b1;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: if (start_hit) state_d = ST_XFER;
      ST_XFER: if (bitpos == LAST_BIT) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= last_bit;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      organ_q <= '0;
      slot_q  <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      organ_q <= req_organ;
      slot_q  <= req_slot;
      write_q <= req_write;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign xfer_write = xfer && write_q;
  assign sel_organ  = organ_q;
  assign done       = done_q;
  assign addr_err   = err_q;

  // R3: a transfer only opens on bit 0 of the latched slot
  a_r3_start_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer) |-> (bitpos == '0 && slot == slot_q));
  // R4: the transfer window closes right after the last bit position
  a_r4_len: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && bitpos == LAST_BIT) |=> !xfer);
  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: a refused request leaves the controller idle
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !busy);
endmodule

// File: rtl/dlm_mem.sv
module dlm_mem #(
  parameter int NUM_ORGANS = 2,
  parameter int ORGAN_W    = 8,
  parameter int SLOT_W     = 5,
  parameter int BIT_W      = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ORGAN_W+SLOT_W-1:0] req_addr,
  input  logic                      wr_bit,
  output logic                      busy,
  output logic                      wr_take,
  output logic                      rd_valid,
  output logic                      rd_bit,
  output logic                      done,
  output logic                      addr_err
);
  localparam int DEPTH = (2 ** SLOT_W) * (2 ** BIT_W);

  logic                  rst_meta_q, rst_int_n;
  logic [SLOT_W-1:0]     slot;
  logic [BIT_W-1:0]      bitpos;
  logic                  xfer, xfer_write;
  logic [ORGAN_W-1:0]    sel_organ;
  logic [NUM_ORGANS-1:0] wr_en, taps;
  logic                  tap_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  dlm_timebase #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .slot   (slot),
    .bitpos (bitpos)
  );

  dlm_ctrl #(
    .NUM_ORGANS (NUM_ORGANS),
    .ORGAN_W    (ORGAN_W),
    .SLOT_W     (SLOT_W),
    .BIT_W      (BIT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .slot       (slot),
    .bitpos     (bitpos),
    .busy       (busy),
    .xfer       (xfer),
    .xfer_write (xfer_write),
    .sel_organ  (sel_organ),
    .done       (done),
    .addr_err   (addr_err)
  );

  for (genvar g = 0; g < NUM_ORGANS; g++) begin : g_organ
    assign wr_en[g] = xfer_write && (sel_organ == ORGAN_W'(g));
    dlm_organ #(.DEPTH(DEPTH)) u_organ (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .wr_en  (wr_en[g]),
      .wr_bit (wr_bit),
      .tap    (taps[g])
    );
  end

  always_comb begin
    tap_sel = 1'b0;
    for (int g = 0; g < NUM_ORGANS; g++) begin
      if (sel_organ == ORGAN_W'(g)) tap_sel = taps[g];
    end
  end

  assign wr_take  = xfer_write;
  assign rd_valid = xfer && !xfer_write;
  assign rd_bit   = rd_valid && tap_sel;

  // R5: at most one organ takes substituted bits in any cycle
  a_r5_one_writer: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(wr_en));
  // R7: an access only begins after a request seen while idle
  a_r7_accept_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/dlm_mem_bench.sv
module dlm_mem_bench;
  localparam int NORG = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic        wr_bit = 1'b0;
  logic        busy, wr_take, rd_valid, rd_bit, done, addr_err;

  always #10 clk = ~clk;

  dlm_mem #(.NUM_ORGANS(NORG)) u_dlm_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .wr_bit(wr_bit), .busy(busy), .wr_take(wr_take),
    .rd_valid(rd_valid), .rd_bit(rd_bit), .done(done), .addr_err(addr_err)
  );

  typedef struct {
    int          slot;
    int          req_cyc;
    bit          is_rd;
    logic [31:0] data;
  } item_t;

  item_t       sb_q[$];
  item_t       cur;
  int          total = 0, bad = 0;
  int          cyc = 0;
  int          phase = 0;
  bit          phase_known = 0;
  logic [31:0] model [0:NORG*32-1];
  logic [31:0] shreg;
  int          nbits = 0;
  bit          xfer_prev = 0;
  bit          have_cur = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lap(input int x);
    return ((x % 1024) + 1024) % 1024;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected accesses and compares
  always @(negedge clk) begin
    bit xfer_now;
    xfer_now = rd_valid || wr_take;
    if (rst_n && done && !(xfer_prev && !xfer_now))
      check(0, "R6 stray done", 1, 0);
    if (xfer_now && !xfer_prev) begin
      if (sb_q.size() == 0) begin
        check(0, "R7 unexpected access", 1, 0);
        have_cur = 0;
      end else begin
        cur = sb_q.pop_front();
        have_cur = 1;
        nbits = 0;
        shreg = '0;
        if (!phase_known) begin
          phase = cyc - cur.slot * 32;
          phase_known = 1;
        end else begin
          int cnt_k, exp_c;
          cnt_k = lap(cur.req_cyc - phase);
          exp_c = cur.req_cyc + lap(cur.slot * 32 - cnt_k - 1) + 1;
          check(cyc == exp_c, "R3 start cycle", cyc, exp_c);
        end
        check(rd_valid == cur.is_rd, "R5 direction", rd_valid, cur.is_rd);
      end
    end
    if (xfer_now) begin
      if (rd_valid && nbits < 32) shreg[nbits] = rd_bit;
      nbits++;
    end
    if (xfer_prev && !xfer_now && have_cur) begin
      check(nbits == 32, "R4 burst length", nbits, 32);
      check(done && !busy, "R6 done after last bit", {done, busy}, 2'b10);
      if (cur.is_rd) check(shreg == cur.data, "R4 read data", shreg, cur.data);
      have_cur = 0;
    end
    xfer_prev = xfer_now;
  end

  // target < 0: issue as soon as idle; else issue in the cycle with that lap count
  task automatic issue(input int org, input int slot, input bit wr, input int target);
    item_t it;
    @(negedge clk);
    while (busy || (target >= 0 && lap(cyc - phase) != target)) @(negedge clk);
    it.slot = slot; it.is_rd = !wr; it.req_cyc = cyc;
    it.data = model[org*32 + slot];
    sb_q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = 13'((org << 5) | slot);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input int org, input int slot, input int target);
    issue(org, slot, 1'b0, target);
    while (busy) @(negedge clk);
  endtask

  task automatic do_write(input int org, input int slot, input logic [31:0] d, input int target);
    int idx;
    model[org*32 + slot] = d;
    issue(org, slot, 1'b1, target);
    idx = 0;
    while (idx < 32) begin
      if (wr_take) begin
        wr_bit = d[idx];
        idx++;
      end
      @(negedge clk);
    end
    wr_bit = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic bad_req(input int org, input int slot);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; wr_bit = 1'b1;
    req_addr = 13'((org << 5) | slot);
    @(negedge clk);
    req_valid = 1'b0;
    check(addr_err && !busy, "R8 error pulse", {addr_err, busy}, 2'b10);
    @(negedge clk);
    check(!addr_err && !busy && !wr_take, "R8 pulse ends, no access",
          {addr_err, busy, wr_take}, 3'b000);
    wr_bit = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NORG*32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    check({busy, rd_valid, wr_take, done, addr_err} == 5'b0, "R9 outputs after reset",
          {busy, rd_valid, wr_take, done, addr_err}, 0);
    do_read(0, 7, -1);                 // R9 zero contents; fixes the lap phase
    do_write(0, 7, 32'hA5A5_3C3C, -1); // R5
    do_write(1, 7, 32'h0F0F_1234, -1); // R2 same slot, other organ
    do_write(0, 8, 32'hDEAD_BEEF, -1);
    do_write(1, 31, 32'h8000_0001, -1);
    do_write(0, 0, 32'hFFFF_FFFF, -1);
    do_read(0, 7, -1);  do_read(0, 7, -1);   // R4 read leaves data intact
    do_read(1, 7, -1);  do_read(0, 8, -1);
    do_read(1, 31, -1); do_read(0, 0, -1);
    do_read(0, 6, -1);  do_read(1, 6, -1);  do_read(0, 9, -1); // R5 neighbours
    do_read(1, 31, 31*32);        // R3 lands on start: full lap
    do_read(0, 8, 8*32 - 1);      // R3 one cycle early: next cycle
    do_write(1, 0, 32'h1357_9BDF, 0);
    do_read(1, 0, -1);
    // R7: request while busy is ignored
    issue(0, 20, 1'b0, 20*32 + 40);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 13'((1 << 5) | 20); wr_bit = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0; wr_bit = 1'b0;
    while (busy) @(negedge clk);
    do_read(1, 20, -1);
    // R8 out-of-range organs
    bad_req(2, 3);
    bad_req(255, 7);
    do_read(1, 3, -1);
    do_read(1, 7, -1);
    // R1 long idle retention
    repeat (3000) @(negedge clk);
    do_read(0, 8, -1);
    do_read(1, 0, -1);
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R7 all accesses seen", sb_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule